// File: doc/BRIEF.md
# YUV Bus Input Formatter

This block sits at the front of a video pipeline and takes in a 16-bit parallel pixel bus made of one luminance byte and one chroma byte per pixel. Capture happens on the rising clock edge, but only on edges where a qualifier input is high. Holding the qualifier high takes data on every edge. Toggling it at half the clock rate takes data on every second edge.

The chroma byte carries U and V time-multiplexed in one of two packings. In the 4:2:2 packing, U and V alternate byte by byte. In the 4:1:1 packing, each pixel carries a two-bit slice of U and a two-bit slice of V, so one complete U/V pair needs four pixels. The block separates the packing back into whole U and V samples. It converts every sample to two's complement and presents Y, U and V with one-cycle valid strobes and a registered active-line flag. Three static configuration inputs set the behaviour: the packing, the 7-bit or 8-bit resolution, and the code of the incoming chroma.

Top module: `yuv_bus_unpack`

## Requirements
- R1: An edge with `smp_qual` low captures nothing. On the following cycle `y_vld` and `c_vld` are 0 and `y_out`, `u_out`, `v_out` and `act_out` keep their previous values.
- R2: Each edge with `smp_qual` and `line_act` both high drives `y_vld` to 1 for one cycle after that edge. On the same cycle `y_out` equals the captured luminance byte with bit 7 inverted.
- R3: On every qualified edge, `act_out` takes the value of `line_act`. The first qualified edge with `line_act` high after a qualified edge with it low is pixel 0. Qualified edges with `line_act` low produce no strobes.
- R4: With `fmt411` = 0 (4:2:2), an even pixel's chroma byte is U and the following odd pixel's chroma byte is V. `c_vld` pulses after each odd pixel, presenting that U and V together, and two pulses are never adjacent.
- R5: With `fmt411` = 1 (4:1:1), chroma bits 7:6 carry two U bits and bits 5:4 carry two V bits, most significant pair first, over pixels 0..3 of each group. `c_vld` pulses after the fourth pixel with the assembled U and V.
- R6: In 4:1:1 mode, a group left incomplete when the line ends produces no `c_vld`, and the next line starts a fresh group at pixel 0.
- R7: With `c_offset` = 1 the chroma samples are offset binary and bit 7 of each assembled sample is inverted. With `c_offset` = 0 they pass unchanged as two's complement.
- R8: With `full_res` = 0 (7-bit data), bit 0 of each luminance byte and of each chroma sample (the chroma byte in 4:2:2, the assembled byte in 4:1:1) is forced to 0 before conversion. With `full_res` = 1 all eight bits are kept.
- R9: While `rst_n` is low, `y_vld`, `c_vld` and `act_out` are 0, all data outputs are 0, and the pixel phase returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-locked pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_qual | input | 1 | Capture qualifier; data is taken only on edges where it is high |
| line_act | input | 1 | High during active pixels of a line |
| y_in | input | 8 | Luminance byte, unsigned |
| c_in | input | 8 | Multiplexed chroma byte |
| fmt411 | input | 1 | 1 selects 4:1:1 packing, 0 selects 4:2:2 |
| full_res | input | 1 | 1 selects 8-bit data, 0 selects 7-bit data |
| c_offset | input | 1 | 1 for offset-binary chroma, 0 for two's complement |
| y_out | output | 8 | Signed luminance sample |
| y_vld | output | 1 | One-cycle strobe for `y_out` |
| u_out | output | 8 | Signed U sample |
| v_out | output | 8 | Signed V sample |
| c_vld | output | 1 | One-cycle strobe for the `u_out`/`v_out` pair |
| act_out | output | 1 | Registered active-line flag |

## Verification
The assertions assume that the three configuration inputs change only while no line is in progress, and only after at least two qualified edges with `line_act` low, so that no strobe from the old setting is still pending. They also assume that in 4:1:1 mode the low chroma nibble is zero. The stimulus respects both assumptions. It changes configuration only inside an idle gap of four qualified cycles between lines, and it clears the low nibble of every random 4:1:1 chroma byte. Inside a line, the qualifier is driven as always high, as a strict half-rate toggle, or at random, so captured and skipped edges interleave in every pattern.

// File: rtl/yuvu_pkg.sv
package yuvu_pkg;
  localparam int unsigned YUVU_W = 8;

  typedef logic [YUVU_W-1:0] smp_t;

  // clear the LSB when running with 7-bit data
  function automatic smp_t trim_res(input smp_t b, input logic full);
    return full ? b : {b[YUVU_W-1:1], 1'b0};
  endfunction

  // unsigned luminance -> signed: flip the top bit
  function automatic smp_t luma_signed(input smp_t b);
    return {~b[YUVU_W-1], b[YUVU_W-2:0]};
  endfunction

  // chroma -> signed, flipping the top bit only for offset-binary input
  function automatic smp_t chroma_signed(input smp_t b, input logic offs);
    return offs ? {~b[YUVU_W-1], b[YUVU_W-2:0]} : b;
  endfunction
endpackage

// File: rtl/yuvu_phase.sv
module yuvu_phase #(
  parameter int unsigned DW = 8,
  localparam int unsigned GRP = DW / 2,
  localparam int unsigned PW = $clog2(GRP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          qual,
  input  logic          line_act,
  input  logic          fmt411,
  output logic          take,
  output logic          even_px,
  output logic          pair_done,
  output logic          act_q,
  output logic [PW-1:0] phase
);
  assign take      = qual && line_act;
  assign even_px   = take && !phase[0];
  assign pair_done = take && (fmt411 ? (phase == PW'(GRP - 1)) : phase[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      act_q <= 1'b0;
    end else if (qual) begin
      act_q <= line_act;
      if (!line_act)                  phase <= '0;
      else if (phase == PW'(GRP - 1)) phase <= '0;
      else                            phase <= phase + 1'b1;
    end
  end

  // pixel 0 is the first active capture, so the phase has moved to 1
  assert_first_pixel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> (phase == PW'(1)));
endmodule

// File: rtl/yuvu_luma.sv
module yuvu_luma
  import yuvu_pkg::*;
#(
  parameter int unsigned DW = YUVU_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          full,
  input  logic [DW-1:0] y_in,
  output logic [DW-1:0] y_out,
  output logic          y_vld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_out <= '0;
      y_vld <= 1'b0;
    end else begin
      y_vld <= take;
      if (take) y_out <= luma_signed(trim_res(y_in, full));
    end
  end

  assert_lsb_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (y_vld && !full) |-> !y_out[0]);
endmodule

// File: rtl/yuvu_chroma.sv
module yuvu_chroma
  import yuvu_pkg::*;
#(
  parameter int unsigned DW = YUVU_W,
  localparam int unsigned AW = DW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          even_px,
  input  logic          pair_done,
  input  logic          fmt411,
  input  logic          full,
  input  logic          offs,
  input  logic [DW-1:0] c_in,
  output logic [DW-1:0] u_out,
  output logic [DW-1:0] v_out,
  output logic          c_vld
);
  logic [DW-1:0] u_hold;
  logic [AW-1:0] u_acc, v_acc;
  logic [DW-1:0] u_full, v_full;

  // bits DW-1:DW-2 are the U slice, DW-3:DW-4 the V slice of a 4:1:1 byte
  assign u_full = fmt411 ? {u_acc, c_in[DW-1:DW-2]} : u_hold;
  assign v_full = fmt411 ? {v_acc, c_in[DW-3:DW-4]} : c_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      u_hold <= '0;
      u_acc  <= '0;
      v_acc  <= '0;
      u_out  <= '0;
      v_out  <= '0;
      c_vld  <= 1'b0;
    end else begin
      c_vld <= pair_done;
      if (even_px && !fmt411) u_hold <= c_in;
      if (take && fmt411) begin
        u_acc <= {u_acc[AW-3:0], c_in[DW-1:DW-2]};
        v_acc <= {v_acc[AW-3:0], c_in[DW-3:DW-4]};
      end
      if (pair_done) begin
        u_out <= chroma_signed(trim_res(u_full, full), offs);
        v_out <= chroma_signed(trim_res(v_full, full), offs);
      end
    end
  end

  // pairs need at least two pixels in either packing (R5 alike)
  assert_pair_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    c_vld |=> !c_vld);
endmodule

// File: rtl/yuv_bus_unpack.sv
module yuv_bus_unpack
  import yuvu_pkg::*;
#(
  parameter int unsigned DW = YUVU_W,
  localparam int unsigned PW = $clog2(DW / 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_qual,
  input  logic          line_act,
  input  logic [DW-1:0] y_in,
  input  logic [DW-1:0] c_in,
  input  logic          fmt411,
  input  logic          full_res,
  input  logic          c_offset,
  output logic [DW-1:0] y_out,
  output logic          y_vld,
  output logic [DW-1:0] u_out,
  output logic [DW-1:0] v_out,
  output logic          c_vld,
  output logic          act_out
);
  logic          take, even_px, pair_done;
  logic [PW-1:0] phase;

  yuvu_phase #(.DW(DW)) i_phase (
    .clk(clk), .rst_n(rst_n), .qual(smp_qual), .line_act(line_act),
    .fmt411(fmt411), .take(take), .even_px(even_px), .pair_done(pair_done),
    .act_q(act_out), .phase(phase)
  );

  yuvu_luma #(.DW(DW)) i_luma (
    .clk(clk), .rst_n(rst_n), .take(take), .full(full_res),
    .y_in(y_in), .y_out(y_out), .y_vld(y_vld)
  );

  yuvu_chroma #(.DW(DW)) i_chroma (
    .clk(clk), .rst_n(rst_n), .take(take), .even_px(even_px),
    .pair_done(pair_done), .fmt411(fmt411), .full(full_res),
    .offs(c_offset), .c_in(c_in), .u_out(u_out), .v_out(v_out), .c_vld(c_vld)
  );

  assert_hold_without_qual_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_qual |=> (!y_vld && !c_vld && $stable(y_out) && $stable(u_out)));

  assert_chroma_in_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_vld |-> (act_out && y_vld));
endmodule

// File: tb/test_yuv_bus_unpack.sv
module test_yuv_bus_unpack;
  localparam time PER = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q = 1'b0, la = 1'b0, fmt = 1'b0, full = 1'b1, offs = 1'b0;
  logic [7:0] yb = '0, cb = '0;
  logic [7:0] y_out, u_out, v_out;
  logic y_vld, c_vld, act_out;

  int checks = 0, fails = 0, cv_seen = 0;
  bit done = 0;

  // bench model state
  logic [7:0] e_y = 0, e_u = 0, e_v = 0, uh = 0, ua = 0, va = 0;
  bit e_yv = 0, e_cv = 0, e_act = 0;
  int bph = 0;

  always #(PER/2) clk = ~clk;

  yuv_bus_unpack i_yuv_bus_unpack (
    .clk(clk), .rst_n(rst_n), .smp_qual(q), .line_act(la), .y_in(yb), .c_in(cb),
    .fmt411(fmt), .full_res(full), .c_offset(offs), .y_out(y_out), .y_vld(y_vld),
    .u_out(u_out), .v_out(v_out), .c_vld(c_vld), .act_out(act_out)
  );

  function automatic logic [7:0] m_y(logic [7:0] b);
    logic [7:0] t = full ? b : (b & 8'hFE);
    return t ^ 8'h80;
  endfunction

  function automatic logic [7:0] m_c(logic [7:0] b);
    logic [7:0] t = full ? b : (b & 8'hFE);
    return offs ? (t ^ 8'h80) : t;
  endfunction

  task automatic check(string tag, logic [7:0] a, logic [7:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  // compare the outputs of the last edge, drive new inputs, advance model
  task automatic cyc(bit nq, bit nla, logic [7:0] ny, logic [7:0] nc);
    string ct;
    ct = fmt ? "R5" : "R4";
    if (offs) ct = {ct, " R7"};
    if (!full) ct = {ct, " R8"};
    check("R1 R3 y_vld", {7'b0, y_vld}, {7'b0, e_yv});
    check("R1 R3 act_out", {7'b0, act_out}, {7'b0, e_act});
    check({ct, " c_vld"}, {7'b0, c_vld}, {7'b0, e_cv});
    check(full ? "R2 y_out" : "R2 R8 y_out", y_out, e_y);
    check({ct, " u_out"}, u_out, e_u);
    check({ct, " v_out"}, v_out, e_v);
    if (c_vld) cv_seen++;
    q = nq; la = nla; yb = ny; cb = nc;
    e_yv = 0; e_cv = 0;
    if (nq) begin
      e_act = nla;
      if (nla) begin
        e_yv = 1;
        e_y = m_y(ny);
        if (fmt) begin
          ua = {ua[5:0], nc[7:6]};
          va = {va[5:0], nc[5:4]};
          if (bph % 4 == 3) begin e_u = m_c(ua); e_v = m_c(va); e_cv = 1; end
        end else if (bph % 2 == 0) begin
          uh = nc;
        end else begin
          e_u = m_c(uh); e_v = m_c(nc); e_cv = 1;
        end
        bph++;
      end else bph = 0;
    end
    @(negedge clk);
  endtask

  task automatic gap(bit nfmt, bit nfull, bit noffs);
    for (int i = 0; i < 4; i++) begin
      if (i == 2) begin fmt = nfmt; full = nfull; offs = noffs; end
      cyc(1'b1, 1'b0, 8'h00, 8'h00);
    end
  endtask

  initial begin
    logic [7:0] ud, vd;
    int qm, len;
    bit qt;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 y_vld", {7'b0, y_vld}, 8'h0);
    check("R9 c_vld", {7'b0, c_vld}, 8'h0);
    check("R9 act_out", {7'b0, act_out}, 8'h0);
    check("R9 y_out", y_out, 8'h0);
    check("R9 u_out", u_out, 8'h0);
    rst_n = 1'b1;
    gap(1'b1, 1'b1, 1'b0);

    // R5/R6 directed: partial 4:1:1 group then a full one
    ud = 8'hB4; vd = 8'h6C;
    cv_seen = 0;
    for (int k = 0; k < 6; k++)
      cyc(1'b1, 1'b1, 8'(k), {ud[7-2*(k%4) -: 2], vd[7-2*(k%4) -: 2], 4'b0});
    gap(1'b1, 1'b1, 1'b0);
    ud = 8'h1E; vd = 8'hC3;
    for (int k = 0; k < 4; k++)
      cyc(1'b1, 1'b1, 8'h10, {ud[7-2*k -: 2], vd[7-2*k -: 2], 4'b0});
    check("R5 u assembled", u_out, 8'h1E);
    check("R5 v assembled", v_out, 8'hC3);
    cyc(1'b1, 1'b0, 8'h0, 8'h0);
    check("R6 pairs over partial+full line", 8'(cv_seen), 8'd2);

    // R2/R4 directed: 4:2:2 boundary values, half-rate qualifier
    gap(1'b0, 1'b1, 1'b1);
    for (int k = 0; k < 8; k++) begin
      cyc(1'b1, 1'b1, (k % 2) ? 8'hFF : 8'h00, (k % 2) ? 8'h80 : 8'h7F);
      cyc(1'b0, 1'b1, 8'hAA, 8'h55);
    end

    // random lines
    void'($urandom(32'h5EED_0417));
    for (int ln = 0; ln < 300; ln++) begin
      gap(1'($urandom), 1'($urandom), 1'($urandom));
      len = 1 + ($urandom % 13);
      qm = $urandom % 3;
      qt = 1'b1;
      for (int k = 0; k < len * 2; k++) begin
        bit nq;
        logic [7:0] rc;
        nq = (qm == 0) ? 1'b1 : (qm == 1) ? qt : 1'($urandom);
        qt = ~qt;
        rc = 8'($urandom);
        if (fmt) rc = rc & 8'hF0;
        cyc(nq, 1'b1, 8'($urandom), rc);
      end
    end
    gap(1'b0, 1'b1, 1'b0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule